// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

This block switches four supply rails on and off in a programmed order. Each rail has a rail-good flag from an external undervoltage comparator, a gate-enable output to its switch, a gate-fully-on status input from that switch, and a fast-discharge flag. A debounced enable input, whose active level is fixed by a parameter, starts the power-up and power-down sequences. Every rail-good flag and the enable pass through a filter, so that a dip shorter than the filter window has no effect.

Power-up begins once the enable is asserted and all four rails are good. The block then waits out a lockout interval, after which the four on-delay timers start in the same cycle. Each gate turns on when its own timer expires. When every switch reports fully on, a settle interval runs and the active-low sequence-complete output is then released. Power-down starts all four off-delay timers together the moment the enable drops. There is no lockout on power-down, and the gates turn off with normal-strength discharge.

A wired-AND system-reset bus is shared between chained controllers. The block pulls the bus low on any filtered rail fault. Whenever it senses the bus low, it forces every gate off with the fast-discharge flag set. If the bus is held low by a neighbour and then released while this controller is already satisfied, the on-delay timers start at once, with no lockout. All delays and intervals are counted in clock cycles.

Top module: `rail_seq_ctrl`

## Requirements
- R1: A rail-good input or the enable changes its filtered value only after the raw value has differed for FILT_CYC consecutive cycles. A dip of FILT_CYC-2 cycles leaves the gates, `rst_n_out` and `sysrst_pull` unchanged.
- R2: No gate turns on until the enable is asserted and all four rails are good. After the block releases the bus, the first on-delay timer starts LOCK_CYC+2 cycles after the bus rises, with a tolerance of 2 cycles.
- R3: All four on-delay timers start in the same cycle. Gate i (i = 0..3 maps to bits of `on_dly` at [i*DW +: DW]) turns on exactly on_dly[i] cycles after that start.
- R4: A rail with a zero delay switches at the start instant. On power-up that is the cycle the lockout ends. On power-down it is the same cycle that `rst_n_out` falls.
- R5: `rst_n_out` rises RSTD_CYC+1 cycles after the cycle in which all `gate_full_on` bits are first high. It is high only while all gates are on.
- R6: When the enable is deasserted and no fault is present, all off-delay timers start in the cycle `rst_n_out` falls. Gate i turns off exactly off_dly[i] cycles later, and `fast_dis` stays 0.
- R7: `sysrst_pull` (1 = pull the bus low) is released once the enable and all rails are good. On a normal power-down it is asserted in the same cycle that the last gate turns off.
- R8: A filtered rail fault asserts `sysrst_pull`, clears all gates, sets all four `fast_dis` bits and drops `rst_n_out` in the following cycle. Gates whose on-timers are still pending never turn on.
- R9: When the bus is pulled low externally, all gates are 0 and `rst_n_out` is 0 by the second rising edge after the bus falls, and `fast_dis` is set.
- R10: If the bus rises while the enable and all rails are already good, the zero-delay gate turns on within 4 cycles, with no lockout. The on-delay differences of R3 still hold.
- R11: Once the fault clears, the full power-up sequence restarts with no other stimulus, ending with all gates on, `fast_dis` cleared and `rst_n_out` high.
- R12: With EN_ACT_LOW=1 the enable is asserted when `en_in` is 0. Holding `en_in` at 1 with all rails good keeps the gates off and the bus pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_in | input | 1 | Raw enable, polarity set by EN_ACT_LOW |
| rail_good | input | NRAIL | Raw per-rail above-threshold flags |
| on_dly | input | NRAIL*DW | Per-rail turn-on delays in cycles, rail i at [i*DW +: DW] |
| off_dly | input | NRAIL*DW | Per-rail turn-off delays in cycles, same packing |
| gate_full_on | input | NRAIL | Switch reports gate fully enhanced |
| sysrst_in | input | 1 | Sensed level of the shared wired-AND bus |
| gate_en | output | NRAIL | Gate enable per rail |
| fast_dis | output | NRAIL | Fast discharge requested (forced turn-off) |
| sysrst_pull | output | 1 | 1 = pull the shared bus low |
| rst_n_out | output | 1 | Active-low sequence-complete output |

## Verification
The bench measures the exact cycle gaps between gate edges on both power-up and power-down. A controller that staggers its timer starts, or that adds a lockout on power-down, shifts these gaps and is caught. A rail fault is injected after some gates are on and others are still pending, so a design that lets a pending timer finish after the fault shows a late gate rise. The shared bus is pulled low by a modelled neighbour and then released while the block is satisfied. A design that cannot tell its own release from an external one either waits through a full lockout or starts without one on a normal power-up, and the measured delay exposes both errors. Short dips of exactly two cycles under the filter window check that the filter boundary sits where R1 places it.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [2:0] {
    SQ_OFF,
    SQ_HELD,
    SQ_LOCK,
    SQ_RAMPON,
    SQ_SETTLE,
    SQ_RUN,
    SQ_RAMPOFF
  } seq_state_t;

  typedef enum logic [1:0] {
    CH_IDLE,
    CH_ON_CNT,
    CH_OFF_CNT
  } chan_mode_t;

endpackage

// File: rtl/sig_filter.sv
module sig_filter #(
  parameter int FILT_CYC = 700,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

  logic          smp;
  logic [FW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp  <= RST_VAL;
      dout <= RST_VAL;
      cnt  <= '0;
    end else begin
      smp <= din;
      if (smp == dout) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        dout <= smp;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (smp == dout) |=> $stable(dout)); // R1

endmodule

// File: rtl/rail_chan.sv
module rail_chan
  import rail_seq_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_on,
  input  logic          start_off,
  input  logic          force_off,
  input  logic [DW-1:0] on_dly,
  input  logic [DW-1:0] off_dly,
  output logic          gate_en,
  output logic          fast_dis,
  output logic          off_final
);
  chan_mode_t    mode;
  logic [DW-1:0] cnt;

  // idle, or the off timer expires at the coming edge
  assign off_final = (mode != CH_OFF_CNT) || (cnt == DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= CH_IDLE;
      cnt      <= '0;
      gate_en  <= 1'b0;
      fast_dis <= 1'b0;
    end else if (force_off) begin
      mode     <= CH_IDLE;
      cnt      <= '0;
      gate_en  <= 1'b0;
      fast_dis <= 1'b1;
    end else if (start_on) begin
      fast_dis <= 1'b0;
      if (on_dly == '0) begin
        gate_en <= 1'b1;
        mode    <= CH_IDLE;
      end else begin
        cnt  <= on_dly;
        mode <= CH_ON_CNT;
      end
    end else if (start_off) begin
      if (off_dly == '0) begin
        gate_en <= 1'b0;
        mode    <= CH_IDLE;
      end else begin
        cnt  <= off_dly;
        mode <= CH_OFF_CNT;
      end
    end else begin
      case (mode)
        CH_ON_CNT: begin
          if (cnt == DW'(1)) begin
            gate_en <= 1'b1;
            mode    <= CH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        CH_OFF_CNT: begin
          if (cnt == DW'(1)) begin
            gate_en <= 1'b0;
            mode    <= CH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    force_off |=> (!gate_en && fast_dis)); // R8
  AST_ZERO_ON: assert property (@(posedge clk) disable iff (rst)
    (start_on && !force_off && on_dly == '0) |=> gate_en); // R4
  AST_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    (start_off && !start_on && !force_off && off_dly == '0) |=> !gate_en); // R4

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rail_seq_pkg::*;
#(
  parameter int NRAIL      = 4,
  parameter int DW         = 24,
  parameter int FILT_CYC   = 700,
  parameter int LOCK_CYC   = 1_000_000,
  parameter int RSTD_CYC   = 16_000_000,
  parameter bit EN_ACT_LOW = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_in,
  input  logic [NRAIL-1:0]    rail_good,
  input  logic [NRAIL*DW-1:0] on_dly,
  input  logic [NRAIL*DW-1:0] off_dly,
  input  logic [NRAIL-1:0]    gate_full_on,
  input  logic                sysrst_in,
  output logic [NRAIL-1:0]    gate_en,
  output logic [NRAIL-1:0]    fast_dis,
  output logic                sysrst_pull,
  output logic                rst_n_out
);
  localparam int TMAX = (LOCK_CYC > RSTD_CYC) ? LOCK_CYC : RSTD_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] LOCK_END = TW'(LOCK_CYC - 1);
  localparam logic [TW-1:0] RSTD_END = TW'(RSTD_CYC - 1);

  logic [NRAIL-1:0] ok_f;
  logic [NRAIL-1:0] off_final;
  logic             en_f;
  logic             en_pol;
  logic             all_ok, sat, kill, all_off_soon;
  logic             bus_s, pull_d;
  logic             start_on, start_off, force_off;
  seq_state_t       st, nxt;
  logic [TW-1:0]    tmr;

  assign en_pol = EN_ACT_LOW ? ~en_in : en_in;

  sig_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b0)) u_en_filt (
    .clk(clk), .rst(rst), .din(en_pol), .dout(en_f)
  );

  for (genvar i = 0; i < NRAIL; i++) begin : g_rail
    sig_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b0)) u_filt (
      .clk(clk), .rst(rst), .din(rail_good[i]), .dout(ok_f[i])
    );
    rail_chan #(.DW(DW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .start_on  (start_on),
      .start_off (start_off),
      .force_off (force_off),
      .on_dly    (on_dly[i*DW +: DW]),
      .off_dly   (off_dly[i*DW +: DW]),
      .gate_en   (gate_en[i]),
      .fast_dis  (fast_dis[i]),
      .off_final (off_final[i])
    );
  end

  assign all_ok       = &ok_f;
  assign sat          = all_ok & en_f;
  assign kill         = ~bus_s | ~all_ok;
  assign all_off_soon = &off_final;

  always_comb begin
    nxt = st;
    case (st)
      SQ_OFF: begin
        if (sat) begin
          if (bus_s)        nxt = SQ_LOCK;
          else if (!pull_d) nxt = SQ_HELD;   // bus low, not by this block
        end
      end
      SQ_HELD: begin
        if (!sat)       nxt = SQ_OFF;
        else if (bus_s) nxt = SQ_RAMPON;     // zero-wait start
      end
      SQ_LOCK: begin
        if (kill || !en_f)     nxt = SQ_OFF;
        else if (tmr == LOCK_END) nxt = SQ_RAMPON;
      end
      SQ_RAMPON: begin
        if (kill)       nxt = SQ_OFF;
        else if (!en_f) nxt = SQ_RAMPOFF;
        else if ((&gate_en) && (&gate_full_on)) nxt = SQ_SETTLE;
      end
      SQ_SETTLE: begin
        if (kill)       nxt = SQ_OFF;
        else if (!en_f) nxt = SQ_RAMPOFF;
        else if (tmr == RSTD_END) nxt = SQ_RUN;
      end
      SQ_RUN: begin
        if (kill)       nxt = SQ_OFF;
        else if (!en_f) nxt = SQ_RAMPOFF;
      end
      SQ_RAMPOFF: begin
        if (kill || all_off_soon) nxt = SQ_OFF;
      end
      default: nxt = SQ_OFF;
    endcase
  end

  assign force_off = kill && (st inside {SQ_LOCK, SQ_RAMPON, SQ_SETTLE, SQ_RUN, SQ_RAMPOFF});
  assign start_on  = (nxt == SQ_RAMPON)  && (st != SQ_RAMPON);
  assign start_off = (nxt == SQ_RAMPOFF) && (st != SQ_RAMPOFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_OFF;
      tmr         <= '0;
      bus_s       <= 1'b0;
      pull_d      <= 1'b1;
      sysrst_pull <= 1'b1;
      rst_n_out   <= 1'b0;
    end else begin
      st          <= nxt;
      bus_s       <= sysrst_in;
      pull_d      <= sysrst_pull;
      sysrst_pull <= ~all_ok | (~en_f & (nxt == SQ_OFF));
      rst_n_out   <= (nxt == SQ_RUN);
      if (nxt != st)                            tmr <= '0;
      else if (st == SQ_LOCK || st == SQ_SETTLE) tmr <= tmr + 1'b1;
    end
  end

  AST_BUS_KILL: assert property (@(posedge clk) disable iff (rst)
    !bus_s |=> (gate_en == '0)); // R9
  AST_BUS_RSTN: assert property (@(posedge clk) disable iff (rst)
    !bus_s |=> !rst_n_out); // R9
  AST_FAULT_PULL: assert property (@(posedge clk) disable iff (rst)
    !all_ok |=> sysrst_pull); // R8
  AST_RUN_GATES: assert property (@(posedge clk) disable iff (rst)
    rst_n_out |-> (&gate_en)); // R5
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_LOCK) |-> (gate_en == '0)); // R2
  AST_NO_EN_NO_GATE: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_OFF && !en_f) |-> (gate_en == '0)); // R12

endmodule

// File: tb/sim_rail_seq_ctrl.sv
`timescale 1ns/1ps
module sim_rail_seq_ctrl;
  localparam int NR = 4;
  localparam int DW = 10;
  localparam int FILT = 6;
  localparam int LOCK = 120;
  localparam int RSTD = 200;
  localparam int ONV[NR]  = '{40, 10, 70, 0};
  localparam int OFFV[NR] = '{30, 0, 55, 15};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_in = 1'b1;           // active low: 1 = deasserted
  logic [NR-1:0] rail_good = '0;
  logic ext_pull = 1'b0;
  logic [NR-1:0] fo_s1 = '0, fo_s2 = '0, full_on = '0;
  logic [NR*DW-1:0] on_flat, off_flat;
  logic [NR-1:0] gate_en, fast_dis;
  logic pull, rst_n, bus;

  int cyc = 0, nchk = 0, nfail = 0;
  bit done = 1'b0;
  int rise_t[NR], fall_t[NR];
  int rstn_rise, rstn_fall, pull_rise, bus_rise;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    fo_s1   <= gate_en;
    fo_s2   <= fo_s1;
    full_on <= fo_s2;
  end

  for (genvar i = 0; i < NR; i++) begin : g_pack
    assign on_flat[i*DW +: DW]  = DW'(ONV[i]);
    assign off_flat[i*DW +: DW] = DW'(OFFV[i]);
  end
  assign bus = ~(pull | ext_pull);

  rail_seq_ctrl #(.NRAIL(NR), .DW(DW), .FILT_CYC(FILT), .LOCK_CYC(LOCK),
                  .RSTD_CYC(RSTD), .EN_ACT_LOW(1'b1)) u0 (
    .clk(clk), .rst(rst), .en_in(en_in), .rail_good(rail_good),
    .on_dly(on_flat), .off_dly(off_flat), .gate_full_on(full_on),
    .sysrst_in(bus), .gate_en(gate_en), .fast_dis(fast_dis),
    .sysrst_pull(pull), .rst_n_out(rst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clear_marks();
    for (int i = 0; i < NR; i++) begin rise_t[i] = -1; fall_t[i] = -1; end
    rstn_rise = -1; rstn_fall = -1; pull_rise = -1; bus_rise = -1;
  endtask

  task automatic watch(input int n);
    for (int k = 0; k < n; k++) begin
      logic [NR-1:0] pg;
      logic pr, pp, pb;
      pg = gate_en; pr = rst_n; pp = pull; pb = bus;
      @(negedge clk);
      for (int i = 0; i < NR; i++) begin
        if (!pg[i] && gate_en[i] && rise_t[i] < 0) rise_t[i] = cyc;
        if (pg[i] && !gate_en[i] && fall_t[i] < 0) fall_t[i] = cyc;
      end
      if (!pr && rst_n && rstn_rise < 0) rstn_rise = cyc;
      if (pr && !rst_n && rstn_fall < 0) rstn_fall = cyc;
      if (!pp && pull && pull_rise < 0) pull_rise = cyc;
      if (!pb && bus && bus_rise < 0) bus_rise = cyc;
    end
  endtask

  task automatic wait_run(input int lim);
    for (int k = 0; k < lim && !rst_n; k++) @(negedge clk);
  endtask

  task automatic quiet_down();
    en_in = 1'b1;
    for (int k = 0; k < 400 && !(gate_en == '0 && pull); k++) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (8) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(gate_en == '0 && fast_dis == '0, "R2 reset gates", int'({gate_en, fast_dis}), 0);
    chk(!rst_n && pull, "R7 reset outputs", int'({rst_n, pull}), 1);
    rail_good = '1;
    repeat (30) @(negedge clk);
    chk(gate_en == '0 && pull, "R12 en_in high is deasserted", int'({gate_en, pull}), 1);
  endtask

  task automatic t_power_on();
    clear_marks();
    en_in = 1'b0;
    watch(LOCK + 70 + RSTD + 60);
    chk(rise_t[3] - bus_rise >= LOCK && rise_t[3] - bus_rise <= LOCK + 4,
        "R2 lockout before timers", rise_t[3] - bus_rise, LOCK + 2);
    chk(rise_t[0] - rise_t[3] == ONV[0], "R3 rail0 on delay", rise_t[0] - rise_t[3], ONV[0]);
    chk(rise_t[1] - rise_t[3] == ONV[1], "R3 rail1 on delay", rise_t[1] - rise_t[3], ONV[1]);
    chk(rise_t[2] - rise_t[3] == ONV[2], "R3 rail2 on delay", rise_t[2] - rise_t[3], ONV[2]);
    chk(rstn_rise - rise_t[2] >= RSTD + 1 && rstn_rise - rise_t[2] <= RSTD + 8,
        "R5 settle after full on", rstn_rise - rise_t[2], RSTD + 3);
    chk(rst_n && gate_en == '1, "R5 running state", int'({rst_n, gate_en}), 31);
  endtask

  task automatic t_power_off();
    clear_marks();
    en_in = 1'b1;
    watch(FILT + 90);
    for (int i = 0; i < NR; i++)
      chk(fall_t[i] - rstn_fall == OFFV[i], "R6 off delay (R4 for zero)",
          fall_t[i] - rstn_fall, OFFV[i]);
    chk(fast_dis == '0, "R6 normal discharge", int'(fast_dis), 0);
    chk(pull_rise == fall_t[2], "R7 bus pulled with last gate", pull_rise, fall_t[2]);
  endtask

  task automatic t_glitch();
    en_in = 1'b0;
    wait_run(LOCK + RSTD + 200);
    clear_marks();
    rail_good[2] = 1'b0;
    repeat (FILT - 2) @(negedge clk);
    rail_good[2] = 1'b1;
    watch(20);
    chk(rst_n && gate_en == '1 && !pull && rstn_fall < 0, "R1 short rail dip ignored",
        int'({rst_n, gate_en, pull}), 62);
    en_in = 1'b1;
    repeat (FILT - 2) @(negedge clk);
    en_in = 1'b0;
    watch(20);
    chk(rst_n && gate_en == '1 && rstn_fall < 0, "R1 short enable dip ignored",
        int'({rst_n, gate_en}), 31);
  endtask

  task automatic t_fault_mid();
    quiet_down();
    en_in = 1'b0;
    for (int k = 0; k < LOCK + 50 && !gate_en[3]; k++) @(negedge clk);
    repeat (15) @(negedge clk);
    clear_marks();
    rail_good[0] = 1'b0;
    watch(FILT + 6);
    chk(gate_en == '0 && fast_dis == '1, "R8 forced off with fast discharge",
        int'({gate_en, fast_dis}), 15);
    chk(pull && !rst_n, "R8 bus pulled, reset low", int'({pull, rst_n}), 2);
    watch(100);
    chk(rise_t[2] < 0 && gate_en == '0, "R8 pending timer cancelled", rise_t[2], -1);
    rail_good[0] = 1'b1;
    wait_run(LOCK + RSTD + 300);
    chk(rst_n && gate_en == '1 && fast_dis == '0, "R11 automatic restart",
        int'({rst_n, gate_en, fast_dis}), 496);
  endtask

  task automatic t_bus_kill();
    int rel;
    ext_pull = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(gate_en == '0 && !rst_n, "R9 external bus low kills", int'({gate_en, rst_n}), 0);
    chk(fast_dis == '1, "R9 fast discharge", int'(fast_dis), 15);
    repeat (20) @(negedge clk);
    clear_marks();
    ext_pull = 1'b0;
    rel = cyc;
    watch(100);
    chk(rise_t[3] - rel >= 1 && rise_t[3] - rel <= 4, "R10 zero-wait start",
        rise_t[3] - rel, 2);
    chk(rise_t[1] - rise_t[3] == ONV[1], "R10 delays kept", rise_t[1] - rise_t[3], ONV[1]);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    t_reset();
    t_power_on();
    t_power_off();
    t_glitch();
    t_fault_mid();
    t_bus_kill();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
      report();
      $finish;
    end
  end

endmodule